// File: doc/BRIEF.md
# SAR ADC Control Sequencer

This block is the digital half of an 8-bit successive-approximation converter in a small microcontroller. Software picks one of eight analog inputs, whose 3-bit number is split over two nibble-wide control registers. A start request then runs a fixed nine-step search. The block drives the analog multiplexer select and an 8-bit trial code into an external resistor ladder. It reads back one comparator bit per step, and settles the result one bit at a time from the most significant bit down.

The finished code goes into a result register. The CPU reads it four bits at a time, with an address bit choosing the half. An end-of-conversion flag tells software that the result is fresh.

Conversion steps are paced by a tick in the system clock domain. A parameter fixes where the tick comes from. It is either a free-running prescaler tap, with twelve power-of-two ratios of an instruction-rate enable, or the rising edges of an external pin after a two-flop synchronizer.

Top module: `adc_sar_ctrl`

## Requirements
- R1: After reset, eoc is 0, trial_code is 0, mux_sel is 0, and both result nibbles read as 0.
- R2: On the first conversion tick after a start, the channel is latched and trial_code becomes 0x80 (only the MSB set). On each of the next 8 ticks the bit under test, from bit 7 down to bit 0, is kept when cmp_in is 1 (input at or above the ladder level for the present trial code) and cleared otherwise, and the next lower bit is set for trial. The stored result is therefore the largest code the comparator accepts.
- R3: The channel is formed as follows. Bits 1:0 come from bits 1:0 of control register A, written with reg_sel=0. Bit 2 comes from bit 0 of control register B, written with reg_sel=1.
- R4: rd_data shows result bits 3:0 when rd_ylsb=0 and bits 7:4 when rd_ylsb=1, combinationally.
- R5: eoc rises on the ninth conversion tick of a conversion. With tick period T, that is between 8T+1 and 9T clock cycles after the clock edge that writes the start.
- R6: A write to register A with bit 3 set is a start request, and eoc reads 0 in the cycle after that write.
- R7: A start while a conversion runs abandons it. Its result is never stored, and eoc rises only once, after nine ticks of the new conversion.
- R8: The result register changes only when a conversion completes. Reads during a conversion return the previous result.
- R9: mux_sel holds the latched channel for the whole conversion, even when the control registers are rewritten without a start.
- R10: A write to register A with bit 3 clear, or any write to register B, starts nothing. eoc, the result and mux_sel are left unchanged.
- R11: With USE_EXT_CLK=1, each synchronized rising edge of adck_pin is one conversion tick, and no conversion progresses without edges.
- R12: With the prescaler, tap PRE_SEL=k (0 to 11) gives a tick every INSTR_DIV*2^(k+1) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adck_pin | input | 1 | External conversion clock pin (used when USE_EXT_CLK=1) |
| reg_wr | input | 1 | Control register write strobe |
| reg_sel | input | 1 | Register select: 0 = control A, 1 = control B |
| reg_wdata | input | DATA_W | Write data nibble |
| rd_ylsb | input | 1 | Result half select: 0 = lower nibble, 1 = upper nibble |
| rd_data | output | DATA_W | Selected result nibble |
| cmp_in | input | 1 | Comparator output: 1 when input is at or above the ladder level |
| mux_sel | output | CH_W | Analog multiplexer channel select |
| trial_code | output | RES_W | Trial code driven to the ladder switch tree |
| eoc | output | 1 | End-of-conversion flag |

## Verification
The flag clears one cycle after the start write. A new result and the eoc rise come together on the ninth conversion tick: with the default prescaler that is 8T+1 to 9T cycles after the write, where T is 12 cycles. The scoreboard stamps each expected item with the cycle of its start write. The monitor accepts eoc only inside that window, samples at the falling edge after the rise, and reads both nibbles combinationally at that point. The hold checks for the result and the channel are taken several ticks into a running conversion. The checks that nothing starts wait more than a full conversion time before sampling. The external-clock instance is checked after each pin edge has had three cycles to pass its synchronizer.

// File: rtl/adc_sar_pkg.sv
package adc_sar_pkg;

   typedef enum logic {
      SEL_CTL_A = 1'b0,
      SEL_CTL_B = 1'b1
   } reg_sel_e;

   // Trial code with only the top bit set, sized to the resolution.
   function automatic logic [31:0] msb_only(input int unsigned width);
      logic [31:0] v;
      v = '0;
      v[width-1] = 1'b1;
      return v;
   endfunction

endpackage

// File: rtl/adc_sar_tick.sv
module adc_sar_tick #(
   parameter bit          USE_EXT_CLK = 1'b0,
   parameter int unsigned PRE_W       = 12,
   parameter int unsigned PRE_SEL     = 0,
   parameter int unsigned INSTR_DIV   = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_pin,
   output logic conv_tick
);

   generate
      if (USE_EXT_CLK) begin : g_ext
         logic [2:0] pin_sync;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pin_sync <= '0;
            else        pin_sync <= {pin_sync[1:0], ext_pin};
         end

         assign conv_tick = pin_sync[1] & ~pin_sync[2];
      end else begin : g_pre
         localparam int unsigned DIV_W = $clog2(INSTR_DIV);
         localparam int unsigned TAP_W = PRE_SEL + 1;

         logic [DIV_W-1:0] div_cnt;
         logic [TAP_W-1:0] pre_cnt;
         logic             instr_en;
         logic             pin_unused;

         assign pin_unused = ext_pin;
         assign instr_en   = (div_cnt == DIV_W'(INSTR_DIV - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_cnt <= '0;
               pre_cnt <= '0;
            end else begin
               div_cnt <= instr_en ? '0 : div_cnt + DIV_W'(1);
               if (instr_en) pre_cnt <= pre_cnt + TAP_W'(1);
            end
         end

         assign conv_tick = instr_en & (&pre_cnt);

         if (PRE_SEL >= PRE_W) begin : g_bad_tap
            $error("PRE_SEL must select a tap below PRE_W");
         end
      end
   endgenerate

endmodule

// File: rtl/adc_sar_regs.sv
module adc_sar_regs
   import adc_sar_pkg::*;
#(
   parameter int unsigned DATA_W  = 4,
   parameter int unsigned RES_W   = 8,
   parameter int unsigned CH_W    = 3,
   parameter int unsigned CH_LO_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [RES_W-1:0]  result,
   input  logic              rd_ylsb,
   output logic [CH_W-1:0]   chan,
   output logic              start_req,
   output logic [DATA_W-1:0] rd_data
);

   localparam int unsigned CH_HI_W   = CH_W - CH_LO_W;
   localparam int unsigned START_BIT = DATA_W - 1;

   logic [CH_LO_W-1:0] ch_lo_q;
   logic [CH_HI_W-1:0] ch_hi_q;
   logic               wr_a;
   logic               wr_b;
   logic [DATA_W-1:0]  wdata_unused;

   assign wdata_unused = reg_wdata;
   assign wr_a = reg_wr && (reg_sel == SEL_CTL_A);
   assign wr_b = reg_wr && (reg_sel == SEL_CTL_B);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch_lo_q <= '0;
         ch_hi_q <= '0;
      end else begin
         if (wr_a) ch_lo_q <= reg_wdata[CH_LO_W-1:0];
         if (wr_b) ch_hi_q <= reg_wdata[CH_HI_W-1:0];
      end
   end

   assign chan      = {ch_hi_q, ch_lo_q};
   assign start_req = wr_a && reg_wdata[START_BIT];
   assign rd_data   = rd_ylsb ? result[RES_W-1 -: DATA_W] : result[DATA_W-1:0];

endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
   import adc_sar_pkg::*;
#(
   parameter int unsigned RES_W = 8,
   parameter int unsigned CH_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conv_tick,
   input  logic             start_req,
   input  logic [CH_W-1:0]  chan,
   input  logic             cmp_in,
   output logic [CH_W-1:0]  mux_sel,
   output logic [RES_W-1:0] trial,
   output logic [RES_W-1:0] result,
   output logic             eoc,
   output logic             busy
);

   localparam int unsigned IDX_W = $clog2(RES_W);
   localparam logic [RES_W-1:0] FIRST_TRIAL = RES_W'(msb_only(RES_W));

   logic             start_pend;
   logic [IDX_W-1:0] bit_idx;
   logic             last_bit;

   assign last_bit = (bit_idx == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_pend <= 1'b0;
         mux_sel    <= '0;
         trial      <= '0;
         result     <= '0;
         eoc        <= 1'b0;
         busy       <= 1'b0;
         bit_idx    <= '0;
      end else begin
         if (conv_tick) begin
            if (start_pend) begin
               // step one: take the channel, present the MSB trial
               start_pend <= 1'b0;
               mux_sel    <= chan;
               trial      <= FIRST_TRIAL;
               bit_idx    <= IDX_W'(RES_W - 1);
               busy       <= 1'b1;
            end else if (busy) begin
               trial[bit_idx] <= cmp_in;
               bit_idx        <= bit_idx - IDX_W'(1);
               if (!last_bit) begin
                  trial[bit_idx - IDX_W'(1)] <= 1'b1;
               end else begin
                  busy <= 1'b0;
                  if (!start_req) begin
                     result <= {trial[RES_W-1:1], cmp_in};
                     eoc    <= 1'b1;
                  end
               end
            end
         end
         if (start_req) begin
            start_pend <= 1'b1;
            eoc        <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/adc_sar_ctrl.sv
module adc_sar_ctrl
   import adc_sar_pkg::*;
#(
   parameter int unsigned DATA_W      = 4,
   parameter int unsigned RES_W       = 8,
   parameter int unsigned CH_W        = 3,
   parameter int unsigned CH_LO_W     = 2,
   parameter int unsigned PRE_W       = 12,
   parameter int unsigned PRE_SEL     = 0,
   parameter int unsigned INSTR_DIV   = 6,
   parameter bit          USE_EXT_CLK = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adck_pin,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              rd_ylsb,
   output logic [DATA_W-1:0] rd_data,
   input  logic              cmp_in,
   output logic [CH_W-1:0]   mux_sel,
   output logic [RES_W-1:0]  trial_code,
   output logic              eoc
);

   generate
      if (RES_W != 2 * DATA_W) begin : g_bad_res
         $error("RES_W must be exactly two bus nibbles");
      end
      if (CH_LO_W >= CH_W) begin : g_bad_split
         $error("CH_LO_W must leave at least one bit for register B");
      end
      if (CH_LO_W > DATA_W - 1) begin : g_bad_lo
         $error("channel bits in register A overlap the start bit");
      end
      if (INSTR_DIV < 2) begin : g_bad_div
         $error("INSTR_DIV must be at least 2");
      end
   endgenerate

   logic             conv_tick;
   logic             start_req;
   logic             seq_busy;
   logic [CH_W-1:0]  chan;
   logic [RES_W-1:0] result_q;

   adc_sar_tick #(
      .USE_EXT_CLK (USE_EXT_CLK),
      .PRE_W       (PRE_W),
      .PRE_SEL     (PRE_SEL),
      .INSTR_DIV   (INSTR_DIV)
   ) tick_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_pin   (adck_pin),
      .conv_tick (conv_tick)
   );

   adc_sar_regs #(
      .DATA_W  (DATA_W),
      .RES_W   (RES_W),
      .CH_W    (CH_W),
      .CH_LO_W (CH_LO_W)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .result    (result_q),
      .rd_ylsb   (rd_ylsb),
      .chan      (chan),
      .start_req (start_req),
      .rd_data   (rd_data)
   );

   adc_sar_seq #(
      .RES_W (RES_W),
      .CH_W  (CH_W)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .conv_tick (conv_tick),
      .start_req (start_req),
      .chan      (chan),
      .cmp_in    (cmp_in),
      .mux_sel   (mux_sel),
      .trial     (trial_code),
      .result    (result_q),
      .eoc       (eoc),
      .busy      (seq_busy)
   );

endmodule

// File: rtl/adc_sar_chk.sv
module adc_sar_chk #(
   parameter int unsigned DATA_W = 4,
   parameter int unsigned RES_W  = 8,
   parameter int unsigned CH_W   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_sel,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              conv_tick,
   input logic              busy,
   input logic              eoc,
   input logic [CH_W-1:0]   mux_sel,
   input logic [RES_W-1:0]  trial_code,
   input logic [RES_W-1:0]  result
);

   localparam logic [RES_W-1:0] TOP_ONLY = {1'b1, {(RES_W-1){1'b0}}};

   // R6: a start write clears the flag by the next cycle
   a_r6_start_clears_eoc: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_sel && reg_wdata[DATA_W-1]) |=> !eoc);

   // R9: the channel select moves only on a conversion tick
   a_r9_mux_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !conv_tick) |=> $stable(mux_sel));

   // R8: the result register changes only together with a rising flag
   a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> $rose(eoc));

   // R5: the flag is never up while the search runs
   a_r5_eoc_idle: assert property (@(posedge clk) disable iff (!rst_n)
      eoc |-> !busy);

   // R2: a fresh search begins with only the MSB under trial
   a_r2_first_trial: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (trial_code == TOP_ONLY));

   // R12: ticks are single-cycle pulses
   a_r12_tick_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      conv_tick |=> !conv_tick);

endmodule

bind adc_sar_ctrl adc_sar_chk #(
   .DATA_W (DATA_W),
   .RES_W  (RES_W),
   .CH_W   (CH_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_sel    (reg_sel),
   .reg_wdata  (reg_wdata),
   .conv_tick  (conv_tick),
   .busy       (seq_busy),
   .eoc        (eoc),
   .mux_sel    (mux_sel),
   .trial_code (trial_code),
   .result     (result_q)
);

// File: tb/adc_sar_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_sar_ctrl_tb_top;

   localparam int T = 12;   // conversion tick period in clocks (6 * 2^1)

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       adck_pin = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_sel = 1'b0;
   logic [3:0] reg_wdata = '0;
   logic       rd_ylsb = 1'b0;
   logic [3:0] rd_data, rd_ext;
   logic [2:0] mux_sel, mux_ext;
   logic [7:0] trial_code, trial_ext;
   logic       eoc, eoc_ext;
   logic       cmp_in, cmp_ext;
   logic [7:0] ain [0:7];

   always #2 clk = ~clk;

   assign cmp_in  = (ain[mux_sel] >= trial_code);
   assign cmp_ext = (ain[mux_ext] >= trial_ext);

   adc_sar_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .adck_pin(adck_pin), .reg_wr(reg_wr),
      .reg_sel(reg_sel), .reg_wdata(reg_wdata), .rd_ylsb(rd_ylsb),
      .rd_data(rd_data), .cmp_in(cmp_in), .mux_sel(mux_sel),
      .trial_code(trial_code), .eoc(eoc));

   adc_sar_ctrl #(.USE_EXT_CLK(1'b1)) dut_ext_i (
      .clk(clk), .rst_n(rst_n), .adck_pin(adck_pin), .reg_wr(reg_wr),
      .reg_sel(reg_sel), .reg_wdata(reg_wdata), .rd_ylsb(rd_ylsb),
      .rd_data(rd_ext), .cmp_in(cmp_ext), .mux_sel(mux_ext),
      .trial_code(trial_ext), .eoc(eoc_ext));

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int conv_seen = 0;
   bit done_flag = 1'b0;

   typedef struct {
      logic [2:0] ch;
      logic [7:0] val;
      int         wr_cyc;
   } exp_t;
   exp_t exp_q[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic wr(input logic sel, input logic [3:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   // driver: program channel, start, push expected item (replace drops a pending one)
   task automatic start_conv(input logic [2:0] ch, input bit replace);
      exp_t e;
      wr(1'b1, {3'b000, ch[2]});
      wr(1'b0, {1'b1, 1'b0, ch[1:0]});
      if (replace && exp_q.size() != 0) void'(exp_q.pop_back());
      e.ch = ch; e.val = ain[ch]; e.wr_cyc = cyc;
      exp_q.push_back(e);
   endtask

   task automatic wait_done();
      int n = 0;
      while (exp_q.size() != 0 && n < 12 * T) begin
         @(negedge clk);
         n++;
      end
      chk("R5 conversion completes", exp_q.size(), 0);
   endtask

   task automatic read_result(output logic [7:0] v);
      rd_ylsb = 1'b0; #0.5;
      v[3:0] = rd_data;
      rd_ylsb = 1'b1; #0.5;
      v[7:4] = rd_data;
      rd_ylsb = 1'b0;
   endtask

   // monitor: pop and compare on each eoc rise
   initial begin
      logic eoc_prev = 1'b0;
      forever begin
         @(negedge clk);
         if (rst_n && eoc && !eoc_prev) begin
            conv_seen++;
            if (exp_q.size() == 0) begin
               chk("R7 unexpected eoc", 1, 0);
            end else begin
               exp_t e;
               logic [7:0] v;
               int d;
               e = exp_q.pop_front();
               d = cyc - e.wr_cyc;
               chk("R3 R9 channel at completion", mux_sel, e.ch);
               read_result(v);
               chk("R2 R4 result nibbles", v, e.val);
               chk("R5 R12 eoc latency window", (d >= 8*T+1 && d <= 9*T), 1);
            end
         end
         eoc_prev = eoc;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk("watchdog expired", 1, 0);
      finish_run();
   end

   initial begin
      logic [7:0] v;
      int n0;
      ain[0] = 8'h00; ain[1] = 8'hFF; ain[2] = 8'h80; ain[3] = 8'h7F;
      ain[4] = 8'h5A; ain[5] = 8'hA5; ain[6] = 8'h01; ain[7] = 8'hFE;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 eoc", eoc, 0);
      chk("R1 trial", trial_code, 0);
      chk("R1 mux", mux_sel, 0);
      read_result(v);
      chk("R1 result", v, 0);

      // R2 R3 R4 R5: every channel, assorted codes
      for (int c = 0; c < 8; c++) begin
         start_conv(3'(c), 1'b0);
         wait_done();
      end

      // R6: start clears the flag one cycle later
      chk("R6 eoc set before start", eoc, 1);
      start_conv(3'd3, 1'b0);
      chk("R6 eoc cleared after start", eoc, 0);
      wait_done();

      // R8 R9: stale result and held channel while running
      ain[2] = 8'h3C;
      start_conv(3'd2, 1'b0);
      repeat (3 * T) @(negedge clk);
      read_result(v);
      chk("R8 stale result during conversion", v, 8'h7F);
      wr(1'b1, 4'b0001);
      repeat (T) @(negedge clk);
      chk("R9 mux held during conversion", mux_sel, 3'd2);
      wait_done();

      // R10: non-start writes do nothing
      wr(1'b0, 4'b0001);
      wr(1'b1, 4'b0000);
      repeat (10 * T) @(negedge clk);
      chk("R10 eoc kept", eoc, 1);
      chk("R10 mux kept", mux_sel, 3'd2);
      read_result(v);
      chk("R10 result kept", v, 8'h3C);

      // R7: restart mid-conversion, only the second result appears
      n0 = conv_seen;
      start_conv(3'd4, 1'b0);
      repeat (4 * T) @(negedge clk);
      start_conv(3'd6, 1'b1);
      wait_done();
      repeat (10 * T) @(negedge clk);
      chk("R7 single completion after restart", conv_seen, n0 + 1);

      // R11: external-pin instance saw no edges so far
      chk("R11 no progress without edges eoc", eoc_ext, 0);
      chk("R11 no progress without edges trial", trial_ext, 0);
      start_conv(3'd5, 1'b0);
      for (int k = 0; k < 8; k++) begin
         adck_pin = 1'b1; repeat (4) @(negedge clk);
         adck_pin = 1'b0; repeat (4) @(negedge clk);
      end
      chk("R11 eoc low after eight edges", eoc_ext, 0);
      adck_pin = 1'b1; repeat (4) @(negedge clk);
      adck_pin = 1'b0;
      chk("R11 eoc after ninth edge", eoc_ext, 1);
      chk("R11 ext channel", mux_ext, 3'd5);
      rd_ylsb = 1'b0; #0.5;
      chk("R11 R4 ext lower nibble", rd_ext, 4'h5);
      rd_ylsb = 1'b1; #0.5;
      chk("R11 R4 ext upper nibble", rd_ext, 4'hA);
      rd_ylsb = 1'b0;
      wait_done();
      finish_run();
   end

endmodule